// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a bus-mapped watchdog for a single clock domain. Once software turns it on, a down-counter runs from one of sixteen power-of-two periods. Software keeps the system alive by writing a fixed code word to a restart location before the counter runs out. The first period after the counter is turned on comes from its own field. Every later reload, whether from a restart or from an expiry, uses the restart-period field.

The block has two ways of responding. In direct mode, an expiry drives a system reset pulse straight away. In staged mode, the first expiry raises an interrupt and reloads the counter. A second expiry, with no restart or interrupt clear in between, then drives the reset pulse. Software cannot turn the watchdog off again. Only the block's own reset stops it.

The register bus follows the APB access pattern. A transfer takes effect in the cycle where `psel` and `penable` are both high. There are no wait states.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0 and the count (offset 0x08) reads 0. The interrupt status (offset 0x10) also reads 0, and both `irq_o` and `sys_rst_o` are low.
- R2: Writing control bit 0 as 1 turns the watchdog on, and a later write of 0 to that bit cannot turn it off. Control bit 1 selects the response: 0 is direct, 1 is staged. Bit 1 can be written at any time and reads back.
- R3: The write that turns the watchdog on loads the count with 2^(BASE_EXP+k)-1, where k is bits 7:4 of the range word (offset 0x04). From then on the count falls by one each cycle.
- R4: A write of exactly 0x76 to offset 0x0C while running reloads the count with 2^(BASE_EXP+j)-1, where j is bits 3:0 of the range word. The same write clears the interrupt. Any other value written there changes nothing.
- R5: While the watchdog is off, the count holds its value and restart writes have no effect. Neither output asserts.
- R6: In direct mode, the cycle after the count reaches 0 starts a `sys_rst_o` pulse of exactly RST_PULSE cycles. The count reloads from the restart period, and the interrupt status stays 0.
- R7: In staged mode, the first expiry sets the interrupt (status bit 0 and `irq_o`), reloads the count and leaves `sys_rst_o` low. An expiry while the interrupt is still set starts the reset pulse.
- R8: A read of offset 0x14 returns 0 and clears the interrupt status. After that, the next expiry counts as a first expiry again.
- R9: Offset 0xF4 reads with bit 6 set, to flag fixed periods. Offset 0xF8 returns VERSION and offset 0xFC returns TYPE_ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte offset of the register |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data, valid in the access phase |
| irq_o | output | 1 | First-stage interrupt, level |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the block with BASE_EXP=4 and CNT_W=20, so the shortest periods are 16, 32 and 64 cycles instead of tens of thousands. With periods that short, both stages of the staged response, the full reset pulse and the re-arming after an interrupt clear all happen within a few hundred cycles. Each can then be checked at its exact cycle. RST_PULSE stays at 8, and VERSION and TYPE_ID get distinct values so that the identification reads can be told apart.

// File: rtl/twdog_pkg.sv
package twdog_pkg;
   localparam int unsigned BUS_AW = 8;

   localparam logic [BUS_AW-1:0] OFS_CTRL  = 8'h00;
   localparam logic [BUS_AW-1:0] OFS_RANGE = 8'h04;
   localparam logic [BUS_AW-1:0] OFS_COUNT = 8'h08;
   localparam logic [BUS_AW-1:0] OFS_KICK  = 8'h0C;
   localparam logic [BUS_AW-1:0] OFS_ISTAT = 8'h10;
   localparam logic [BUS_AW-1:0] OFS_ICLR  = 8'h14;
   localparam logic [BUS_AW-1:0] OFS_PARAM = 8'hF4;
   localparam logic [BUS_AW-1:0] OFS_VER   = 8'hF8;
   localparam logic [BUS_AW-1:0] OFS_TYPE  = 8'hFC;

   localparam logic [31:0] KICK_CODE  = 32'h0000_0076;
   localparam int unsigned INIT_LSB   = 4;
   localparam int unsigned FIXED_BIT  = 6;

   typedef enum logic {
      RESP_DIRECT = 1'b0,
      RESP_STAGED = 1'b1
   } resp_mode_e;
endpackage

// File: rtl/twdog_regs.sv
module twdog_regs
   import twdog_pkg::*;
#(
   parameter int unsigned DW           = 32,
   parameter int unsigned AW           = 8,
   parameter int unsigned IDX_W        = 4,
   parameter int unsigned CNT_W        = 32,
   parameter logic [31:0] VERSION      = 32'h0001_0000,
   parameter logic [31:0] TYPE_ID      = 32'h5744_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [AW-1:0]     paddr,
   input  logic [DW-1:0]     pwdata,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              irq_i,
   output logic [DW-1:0]     prdata_o,
   output logic              en_o,
   output resp_mode_e        mode_o,
   output logic [IDX_W-1:0]  rst_idx_o,
   output logic [IDX_W-1:0]  init_idx_o,
   output logic              start_o,
   output logic              kick_o,
   output logic              clr_o
);
   logic access, wr, rd;
   logic hit_ctrl, hit_range, hit_kick, hit_iclr;

   assign access    = psel & penable;
   assign wr        = access & pwrite;
   assign rd        = access & ~pwrite;
   assign hit_ctrl  = (paddr == AW'(OFS_CTRL));
   assign hit_range = (paddr == AW'(OFS_RANGE));
   assign hit_kick  = (paddr == AW'(OFS_KICK));
   assign hit_iclr  = (paddr == AW'(OFS_ICLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o       <= 1'b0;
         mode_o     <= RESP_DIRECT;
         rst_idx_o  <= '0;
         init_idx_o <= '0;
      end else begin
         if (wr && hit_ctrl) begin
            en_o   <= en_o | pwdata[0];
            mode_o <= resp_mode_e'(pwdata[1]);
         end
         if (wr && hit_range) begin
            rst_idx_o  <= pwdata[IDX_W-1:0];
            init_idx_o <= pwdata[INIT_LSB +: IDX_W];
         end
      end
   end

   assign start_o = wr & hit_ctrl & pwdata[0] & ~en_o;
   assign kick_o  = wr & hit_kick & en_o & (pwdata == DW'(KICK_CODE));
   assign clr_o   = rd & hit_iclr;

   always_comb begin
      prdata_o = '0;
      case (paddr)
         AW'(OFS_CTRL): begin
            prdata_o[0] = en_o;
            prdata_o[1] = (mode_o == RESP_STAGED);
         end
         AW'(OFS_RANGE): begin
            prdata_o[IDX_W-1:0]          = rst_idx_o;
            prdata_o[INIT_LSB +: IDX_W]  = init_idx_o;
         end
         AW'(OFS_COUNT): prdata_o[CNT_W-1:0] = count_i;
         AW'(OFS_ISTAT): prdata_o[0] = irq_i;
         AW'(OFS_PARAM): prdata_o[FIXED_BIT] = 1'b1;
         AW'(OFS_VER):   prdata_o = DW'(VERSION);
         AW'(OFS_TYPE):  prdata_o = DW'(TYPE_ID);
         default:        prdata_o = '0;
      endcase
   end
endmodule

// File: rtl/twdog_counter.sv
module twdog_counter #(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned BASE_EXP = 16,
   parameter int unsigned NUM_P    = 16,
   parameter int unsigned IDX_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              start_i,
   input  logic              kick_i,
   input  logic [IDX_W-1:0]  init_idx_i,
   input  logic [IDX_W-1:0]  rst_idx_i,
   output logic [CNT_W-1:0]  count_o,
   output logic              expire_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] reload_tab [NUM_P];

   for (genvar g = 0; g < NUM_P; g++) begin : g_tab
      assign reload_tab[g] = (ONE << (BASE_EXP + g)) - ONE;
   end

   logic at_zero;
   assign at_zero  = (count_o == '0);
   assign expire_o = en_i & at_zero & ~kick_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o <= '0;
      end else if (start_i) begin
         count_o <= reload_tab[init_idx_i];
      end else if (en_i) begin
         if (kick_i || at_zero) count_o <= reload_tab[rst_idx_i];
         else                   count_o <= count_o - ONE;
      end
   end
endmodule

// File: rtl/twdog_resp.sv
module twdog_resp
   import twdog_pkg::*;
#(
   parameter int unsigned RST_PULSE = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire_i,
   input  resp_mode_e mode_i,
   input  logic       kick_i,
   input  logic       clr_i,
   output logic       irq_o,
   output logic       sys_rst_o
);
   localparam int unsigned PW = $clog2(RST_PULSE + 1);

   logic fire_rst, set_irq;
   assign fire_rst = expire_i & ((mode_i == RESP_DIRECT) | irq_o);
   assign set_irq  = expire_i & (mode_i == RESP_STAGED) & ~irq_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               irq_o <= 1'b0;
      else if (set_irq)         irq_o <= 1'b1;
      else if (kick_i || clr_i) irq_o <= 1'b0;
   end

   if (RST_PULSE == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sys_rst_o <= 1'b0;
         else        sys_rst_o <= fire_rst;
      end
   end else begin : g_multi
      logic [PW-1:0] pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              pulse_q <= '0;
         else if (fire_rst)       pulse_q <= PW'(RST_PULSE);
         else if (pulse_q != '0)  pulse_q <= pulse_q - PW'(1);
      end
      assign sys_rst_o = (pulse_q != '0);
   end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
   import twdog_pkg::*;
#(
   parameter int unsigned DW          = 32,
   parameter int unsigned AW          = 8,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned BASE_EXP    = 16,
   parameter int unsigned NUM_PERIODS = 16,
   parameter int unsigned RST_PULSE   = 8,
   parameter logic [31:0] VERSION     = 32'h0001_0000,
   parameter logic [31:0] TYPE_ID     = 32'h5744_0001
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          psel,
   input  logic          penable,
   input  logic          pwrite,
   input  logic [AW-1:0] paddr,
   input  logic [DW-1:0] pwdata,
   output logic [DW-1:0] prdata,
   output logic          irq_o,
   output logic          sys_rst_o
);
   localparam int unsigned IDX_W = $clog2(NUM_PERIODS);

   if (NUM_PERIODS != 16) begin : g_bad_np
      $error("NUM_PERIODS must be 16: the range fields are 4 bits wide");
   end
   if (DW != 32) begin : g_bad_dw
      $error("DW must be 32");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW must cover offsets up to 0xFC");
   end
   if (CNT_W < BASE_EXP + NUM_PERIODS - 1 || CNT_W > DW) begin : g_bad_cw
      $error("CNT_W must hold the longest period and fit the data bus");
   end
   if (RST_PULSE < 1) begin : g_bad_rp
      $error("RST_PULSE must be at least 1");
   end

   logic             en_q;
   resp_mode_e       mode_q;
   logic [IDX_W-1:0] rst_idx, init_idx;
   logic             start, kick, clr, expire;
   logic [CNT_W-1:0] count_q;

   twdog_regs #(
      .DW(DW), .AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W),
      .VERSION(VERSION), .TYPE_ID(TYPE_ID)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata),
      .count_i(count_q), .irq_i(irq_o),
      .prdata_o(prdata), .en_o(en_q), .mode_o(mode_q),
      .rst_idx_o(rst_idx), .init_idx_o(init_idx),
      .start_o(start), .kick_o(kick), .clr_o(clr)
   );

   twdog_counter #(
      .CNT_W(CNT_W), .BASE_EXP(BASE_EXP), .NUM_P(NUM_PERIODS), .IDX_W(IDX_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .en_i(en_q), .start_i(start), .kick_i(kick),
      .init_idx_i(init_idx), .rst_idx_i(rst_idx),
      .count_o(count_q), .expire_o(expire)
   );

   twdog_resp #(
      .RST_PULSE(RST_PULSE)
   ) u_resp (
      .clk(clk), .rst_n(rst_n),
      .expire_i(expire), .mode_i(mode_q),
      .kick_i(kick), .clr_i(clr),
      .irq_o(irq_o), .sys_rst_o(sys_rst_o)
   );
endmodule

// File: rtl/twostage_wdog_chk.sv
module twostage_wdog_chk #(
   parameter int unsigned DW        = 32,
   parameter int unsigned AW        = 8,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned RST_PULSE = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             psel,
   input logic             penable,
   input logic             pwrite,
   input logic [AW-1:0]    paddr,
   input logic [DW-1:0]    pwdata,
   input logic             en,
   input logic             mode,
   input logic [CNT_W-1:0] count,
   input logic             irq,
   input logic             sys_rst
);
   localparam int unsigned HW = $clog2(RST_PULSE + 2);

   logic [HW-1:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_cnt <= '0;
      else if (sys_rst) hi_cnt <= hi_cnt + HW'(1);
      else              hi_cnt <= '0;
   end

   logic kick_seen;
   assign kick_seen = psel & penable & pwrite & en &
                      (paddr == AW'(8'h0C)) & (pwdata == DW'(32'h76));

   // R2: enable cannot be cleared by software
   a_r2_sticky_en: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en) |-> en);

   // R5: off means the count is frozen
   a_r5_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en)) |-> $stable(count));

   // R5: no response while off
   a_r5_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!irq && !sys_rst));

   // R6: pulse never exceeds its length
   a_r6_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |-> (hi_cnt < HW'(RST_PULSE)));

   // R6: pulse ends only after its full length
   a_r6_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst) |-> (hi_cnt == HW'(RST_PULSE)));

   // R7: interrupt only rises in staged mode
   a_r7_irq_staged: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(mode));

   // R7: staged reset only with interrupt pending
   a_r7_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sys_rst) && $past(mode)) |-> $past(irq));

   // R4: magic restart clears the interrupt
   a_r4_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
      kick_seen |=> !irq);
endmodule

bind twostage_wdog twostage_wdog_chk #(
   .DW(DW), .AW(AW), .CNT_W(CNT_W), .RST_PULSE(RST_PULSE)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .psel(psel), .penable(penable), .pwrite(pwrite),
   .paddr(paddr), .pwdata(pwdata),
   .en(en_q), .mode(mode_q), .count(count_q),
   .irq(irq_o), .sys_rst(sys_rst_o)
);

// File: tb/twostage_wdog_tb.sv
`timescale 1ns/1ps
module twostage_wdog_tb;
   localparam int unsigned DW = 32, AW = 8, CNT_W = 20, BASE_EXP = 4, RSTP = 8;
   localparam logic [31:0] VER = 32'h0003_0102, TID = 32'h5744_00A5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [DW-1:0] pwdata = '0;
   logic [DW-1:0] prdata;
   logic irq_o, sys_rst_o;

   int nchk = 0, nerr = 0;
   int cyc = 0;
   int last_ld = 0;
   logic [31:0] rd_v;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   twostage_wdog #(
      .DW(DW), .AW(AW), .CNT_W(CNT_W), .BASE_EXP(BASE_EXP),
      .NUM_PERIODS(16), .RST_PULSE(RSTP), .VERSION(VER), .TYPE_ID(TID)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .irq_o(irq_o), .sys_rst_o(sys_rst_o)
   );

   function automatic logic [31:0] reload_of(input int idx);
      return (32'd1 << (BASE_EXP + idx)) - 32'd1;
   endfunction

   function automatic logic [31:0] exp_count(input int idx, input int ld, input int now);
      return reload_of(idx) - 32'(now - ld);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      @(posedge clk); #1;
      last_ld = cyc;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output int at);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      #1;
      d = prdata; at = cyc;
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) begin
         @(posedge clk); #1;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int at, ld;
      void'($urandom(32'd1234));
      repeat (5) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      bus_rd(8'h00, rd_v, at); check("R1 ctrl", rd_v, 32'h0);
      bus_rd(8'h08, rd_v, at); check("R1 count", rd_v, 32'h0);
      bus_rd(8'h10, rd_v, at); check("R1 istat", rd_v, 32'h0);
      check("R1 outputs", {30'b0, irq_o, sys_rst_o}, 32'h0);

      // R9 identification
      bus_rd(8'hF4, rd_v, at); check("R9 fixed flag", rd_v & 32'h40, 32'h40);
      bus_rd(8'hF8, rd_v, at); check("R9 version", rd_v, VER);
      bus_rd(8'hFC, rd_v, at); check("R9 type", rd_v, TID);

      // R5 off: restart ignored, count frozen, outputs quiet
      bus_wr(8'h04, 32'h21);
      bus_wr(8'h0C, 32'h76);
      repeat (20) @(posedge clk);
      #1;
      bus_rd(8'h08, rd_v, at); check("R5 frozen count", rd_v, 32'h0);
      check("R5 quiet", {30'b0, irq_o, sys_rst_o}, 32'h0);

      // R3 enable loads initial period (index 2 -> 64 cycles)
      bus_wr(8'h00, 32'h1); ld = last_ld;
      bus_rd(8'h08, rd_v, at); check("R3 init load", rd_v, exp_count(2, ld, at));
      repeat (7) @(posedge clk);
      bus_rd(8'h08, rd_v, at); check("R3 decrement", rd_v, exp_count(2, ld, at));

      // R2 enable sticky
      bus_wr(8'h00, 32'h0);
      bus_rd(8'h00, rd_v, at); check("R2 sticky enable", rd_v, 32'h1);

      // R4 non-magic restart ignored
      bus_wr(8'h0C, 32'h77);
      bus_wr(8'h0C, 32'h176);
      bus_rd(8'h08, rd_v, at); check("R4 bad code ignored", rd_v, exp_count(2, ld, at));

      // R4 magic restart reloads restart period (index 1 -> 32 cycles)
      bus_wr(8'h0C, 32'h76); ld = last_ld;
      bus_rd(8'h08, rd_v, at); check("R4 kick reload", rd_v, exp_count(1, ld, at));

      // R6 direct mode expiry
      bus_wr(8'h0C, 32'h76); ld = last_ld;
      wait_to(ld + 31); check("R6 before expiry", {31'b0, sys_rst_o}, 32'h0);
      wait_to(ld + 32); check("R6 pulse start", {31'b0, sys_rst_o}, 32'h1);
      check("R6 no irq", {31'b0, irq_o}, 32'h0);
      wait_to(ld + 39); check("R6 pulse last", {31'b0, sys_rst_o}, 32'h1);
      wait_to(ld + 40); check("R6 pulse end", {31'b0, sys_rst_o}, 32'h0);
      bus_rd(8'h10, rd_v, at); check("R6 istat zero", rd_v, 32'h0);
      bus_rd(8'h08, rd_v, at); check("R6 reload", rd_v, exp_count(1, ld + 32, at));

      // R2 mode bit, R7 staged response
      bus_wr(8'h00, 32'h3);
      bus_rd(8'h00, rd_v, at); check("R2 mode readback", rd_v, 32'h3);
      bus_wr(8'h0C, 32'h76); ld = last_ld;
      wait_to(ld + 31); check("R7 irq before", {31'b0, irq_o}, 32'h0);
      wait_to(ld + 32); check("R7 first irq", {31'b0, irq_o}, 32'h1);
      check("R7 no reset first", {31'b0, sys_rst_o}, 32'h0);
      bus_rd(8'h10, rd_v, at); check("R7 istat set", rd_v, 32'h1);
      wait_to(ld + 63); check("R7 no reset yet", {31'b0, sys_rst_o}, 32'h0);
      wait_to(ld + 64); check("R7 second reset", {31'b0, sys_rst_o}, 32'h1);
      wait_to(ld + 72); check("R7 pulse end", {31'b0, sys_rst_o}, 32'h0);
      bus_wr(8'h0C, 32'h76); ld = last_ld;
      check("R4 kick clears irq", {31'b0, irq_o}, 32'h0);

      // R8 read-clear rearms first stage
      bus_wr(8'h0C, 32'h76); ld = last_ld;
      wait_to(ld + 33); check("R8 irq up", {31'b0, irq_o}, 32'h1);
      bus_rd(8'h14, rd_v, at); check("R8 clear reads 0", rd_v, 32'h0);
      check("R8 irq cleared", {31'b0, irq_o}, 32'h0);
      bus_rd(8'h10, rd_v, at); check("R8 istat cleared", rd_v, 32'h0);
      wait_to(ld + 64); check("R8 rearmed irq", {31'b0, irq_o}, 32'h1);
      check("R8 no reset", {31'b0, sys_rst_o}, 32'h0);
      bus_wr(8'h0C, 32'h76); ld = last_ld;

      // R4 random traffic with timely restarts
      for (int i = 0; i < 300; i++) begin
         int op;
         logic [31:0] v;
         if (cyc - ld > 18) begin
            bus_wr(8'h0C, 32'h76); ld = last_ld;
         end
         op = int'($urandom_range(0, 2));
         case (op)
            0: begin
               bus_rd(8'h08, rd_v, at);
               check("R4 random count", rd_v, exp_count(1, ld, at));
            end
            1: begin
               v = $urandom();
               if (v == 32'h76) v = 32'h75;
               bus_wr(8'h0C, v);
            end
            default: begin
               bus_rd(8'h00, rd_v, at);
               check("R2 random ctrl", rd_v, 32'h3);
            end
         endcase
         check("R4 random quiet", {30'b0, irq_o, sys_rst_o}, 32'h0);
         repeat ($urandom_range(0, 5)) @(posedge clk);
         #1;
      end

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule